// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps a 32-bit count of elapsed seconds and raises an alarm interrupt when the count reaches a programmed value. Software reaches every part of it through a small synchronous byte-wide register bus. The timebase sits outside the block. A one-cycle pulse on `tick_i` stands for one second, and the count advances on that pulse only while the run bit is set.

To set the time, software first stops the counter. It then writes the three upper bytes of the new value into a staging group. The write of the low staging byte copies all four bytes into the counter in the same clock edge, so the count never holds a mix of old and new bytes. A staged low-byte write while the counter runs only updates the staging register.

The alarm compares the count with a 32-bit value that software can read and write. A match that occurs on an enabled tick sets a sticky status bit. The interrupt line gives a one-cycle pulse on every rising edge of status AND alarm enable.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the count, the run bit, the alarm enable, the alarm status and the compare value are all zero, and `irq_o` is low.
- R2: The count is read little-endian at addresses 0x8 (bits 7:0) through 0xB (bits 31:24) and is read-only.
- R3: Bit 7 of address 0x0 is the run bit. While it is set, each cycle with `tick_i` high adds one to the count. While it is clear, the count holds its value.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000 on an enabled tick.
- R5: Addresses 0x4 to 0x7 are staging bytes (0x4 is the least significant) and read back as written. Writes to 0x5 to 0x7 leave the count unchanged. A write to 0x4 while the run bit is clear loads the count with {byte 0x7, byte 0x6, byte 0x5, written data} in one edge.
- R6: A write to 0x4 while the run bit is set leaves the count unchanged.
- R7: The alarm compare value is held little-endian at 0xC (bits 7:0) through 0xF and is read and written there.
- R8: Bit 7 of 0x1 is the alarm enable. Bit 0 of 0x2 is the alarm status. Status sets on a tick where the new count equals the compare value, and only if the alarm enable is set.
- R9: Once set, status stays set through further ticks. A write to 0x2 with bit 0 = 0 clears it. A write with bit 0 = 1 leaves it unchanged.
- R10: `irq_o` is high for exactly one cycle, in the cycle after status AND enable rises. This includes re-enabling the alarm while status is still set.
- R11: Read data appears on `rdata_o` one cycle after the address is presented. Unmapped addresses (0x3) read as zero.
- R12: With the alarm disabled and the compare value at zero, counting through zero sets no status and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle seconds pulse |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe for `wdata_i` at `addr_i` |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
A corrupted count byte or a partial load shows up on the very next read of the four count registers, two cycles after the fault. A lost or spurious status bit shows up as a missing or extra `irq_o` pulse in the cycle right after the matching tick. It also shows on the status register read that follows. A load that wrongly fires while the counter runs, or a tick counted while it is stopped, changes the count seen at the next read, which the bench compares with a model value kept from the requirements alone.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_RUN    = 4'h0;
  localparam logic [ADDR_W-1:0] A_ALM_EN = 4'h1;
  localparam logic [ADDR_W-1:0] A_ALM_ST = 4'h2;
  localparam logic [ADDR_W-1:0] A_LOAD0  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CNT0   = 4'h8;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'hC;
  localparam int unsigned RUN_BIT = 7;
  localparam int unsigned AEN_BIT = 7;
  localparam int unsigned AST_BIT = 0;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o  = cnt_q + CNT_W'(1);
  assign step_o = run_i & tick_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step_o)  cnt_q <= nxt_o;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             stat_o,
  output logic             irq_o
);
  logic stat_q, pend_q, set;

  // set beats a clear landing in the same cycle
  assign set = step_i & en_i & (nxt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (set)        stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
      pend_q <= stat_q & en_i;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_i & ~pend_q;
endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              stat_i,
  output logic              run_o,
  output logic              alm_en_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              stat_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NB = CNT_W / DATA_W;

  logic              run_q, aen_q;
  logic [DATA_W-1:0] stage_q [NB];
  logic [DATA_W-1:0] cmp_q   [NB];
  logic [DATA_W-1:0] rd_d, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      aen_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == A_RUN)    run_q <= wdata_i[RUN_BIT];
      if (wr_en_i && addr_i == A_ALM_EN) aen_q <= wdata_i[AEN_BIT];
      rd_q <= rd_d;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] LD_A = ADDR_W'(A_LOAD0 + g);
    localparam logic [ADDR_W-1:0] CM_A = ADDR_W'(A_CMP0 + g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
        cmp_q[g]   <= '0;
      end else begin
        if (wr_en_i && addr_i == LD_A) stage_q[g] <= wdata_i;
        if (wr_en_i && addr_i == CM_A) cmp_q[g]   <= wdata_i;
      end
    end

    assign cmp_o[g*DATA_W +: DATA_W] = cmp_q[g];
    if (g == 0) begin : g_lsb
      assign load_val_o[DATA_W-1:0] = wdata_i;
    end else begin : g_upper
      assign load_val_o[g*DATA_W +: DATA_W] = stage_q[g];
    end
  end

  assign load_o     = wr_en_i & (addr_i == A_LOAD0) & ~run_q;
  assign stat_clr_o = wr_en_i & (addr_i == A_ALM_ST) & ~wdata_i[AST_BIT];

  always_comb begin
    rd_d = '0;
    if (addr_i == A_RUN)    rd_d[RUN_BIT] = run_q;
    if (addr_i == A_ALM_EN) rd_d[AEN_BIT] = aen_q;
    if (addr_i == A_ALM_ST) rd_d[AST_BIT] = stat_i;
    for (int i = 0; i < NB; i++) begin
      if (addr_i == ADDR_W'(A_LOAD0 + i)) rd_d = stage_q[i];
      if (addr_i == ADDR_W'(A_CNT0 + i))  rd_d = count_i[i*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(A_CMP0 + i))  rd_d = cmp_q[i];
    end
  end

  assign run_o    = run_q;
  assign alm_en_o = aen_q;
  assign rdata_o  = rd_q;
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             run, alm_en, load, stat_clr, alm_stat, step;
  logic [CNT_W-1:0] load_val, count, nxt, cmp;

  rtc_reg_if #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .count_i    (count),
    .stat_i     (alm_stat),
    .run_o      (run),
    .alm_en_o   (alm_en),
    .load_o     (load),
    .load_val_o (load_val),
    .cmp_o      (cmp),
    .stat_clr_o (stat_clr),
    .rdata_o    (rdata_o)
  );

  rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .count_o    (count),
    .nxt_o      (nxt),
    .step_o     (step)
  );

  rtc_alarm_unit #(.CNT_W(CNT_W)) u_alm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .nxt_i  (nxt),
    .cmp_i  (cmp),
    .en_i   (alm_en),
    .clr_i  (stat_clr),
    .stat_o (alm_stat),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             irq_o,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count,
  input logic             alm_en,
  input logic             alm_stat,
  input logic             stat_clr
);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load) |=> $stable(count));

  assert_step_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !load) |=> count == CNT_W'($past(count) + CNT_W'(1)));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> count == $past(load_val));

  assert_no_load_running_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> !run);

  assert_set_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_stat) |-> $past(alm_en));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !(run && tick_i)) |=> !alm_stat);

  assert_irq_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (alm_stat && alm_en));

  assert_irq_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .irq_o    (irq_o),
  .run      (run),
  .load     (load),
  .load_val (load_val),
  .count    (count),
  .alm_en   (alm_en),
  .alm_stat (alm_stat),
  .stat_clr (stat_clr)
);

// File: tb/rtc_sec_alarm_tb_top.sv
`timescale 1ns/1ps
module rtc_sec_alarm_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t sb_q[$];
  logic rd_req = 1'b0;
  logic rd_vld_d = 1'b0;

  always #10 clk = ~clk;

  rtc_sec_alarm dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  always @(posedge clk) rd_vld_d <= rd_req;

  // monitor: compare read data with the queued expectation
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rd_vld_d && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%02h expected=%02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_req = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected byte
  task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
    item_t it;
    @(negedge clk);
    addr = a; wr_en = 1'b0; rd_req = 1'b1;
    it.tag = tag; it.exp = e;
    sb_q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic rd_cnt(logic [31:0] e, string tag);
    for (int i = 0; i < 4; i++) rd(4'(8 + i), e[i*8 +: 8], tag);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_time(logic [31:0] v);
    wr(4'h0, 8'h00);
    wr(4'h4, 8'h00);
    wr(4'h5, v[15:8]);
    wr(4'h6, v[23:16]);
    wr(4'h7, v[31:24]);
    wr(4'h4, v[7:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check("R1 irq after reset", irq, 0);
    rd_cnt(32'h0, "R1 count reset");
    rd(4'h0, 8'h00, "R1 run reset");
    rd(4'h2, 8'h00, "R1 status reset");
    rd(4'hC, 8'h00, "R1 compare reset");
    rd(4'h3, 8'h00, "R11 unmapped");

    // staged load
    wr(4'h5, 8'h22); wr(4'h6, 8'h33); wr(4'h7, 8'h44);
    rd_cnt(32'h0, "R5 staging leaves count");
    rd(4'h6, 8'h33, "R5 staging readback");
    wr(4'h4, 8'h11);
    rd_cnt(32'h44332211, "R2 R5 atomic load");

    do_tick();
    rd_cnt(32'h44332211, "R3 hold while stopped");
    wr(4'h0, 8'h80);
    rd(4'h0, 8'h80, "R3 run readback");
    repeat (3) do_tick();
    rd_cnt(32'h44332214, "R3 counting");

    wr(4'h4, 8'h99);
    rd_cnt(32'h44332214, "R6 no load while running");
    rd(4'h4, 8'h99, "R6 stage still written");

    // wrap
    load_time(32'hFFFFFFFE);
    wr(4'h0, 8'h80);
    do_tick();
    rd_cnt(32'hFFFFFFFF, "R4 before wrap");
    do_tick();
    rd_cnt(32'h0, "R4 wrap");

    // alarm
    wr(4'hC, 8'h03); wr(4'hD, 8'h00); wr(4'hE, 8'h00); wr(4'hF, 8'hA5);
    rd(4'hF, 8'hA5, "R7 compare readback");
    wr(4'hF, 8'h00);
    rd(4'hC, 8'h03, "R7 compare byte0");
    wr(4'h1, 8'h80);
    rd(4'h1, 8'h80, "R8 alarm enable readback");
    do_tick(); do_tick();
    check("R8 no irq before match", irq, 0);
    rd(4'h2, 8'h00, "R8 no status before match");
    do_tick();
    check("R10 irq on match", irq, 1);
    @(negedge clk);
    check("R10 irq one cycle", irq, 0);
    rd(4'h2, 8'h01, "R8 status set");
    do_tick();
    rd(4'h2, 8'h01, "R9 status sticky");
    wr(4'h2, 8'h01);
    rd(4'h2, 8'h01, "R9 write one ignored");
    wr(4'h2, 8'h00);
    rd(4'h2, 8'h00, "R9 cleared");
    check("R10 single pulse so far", irq_cnt, 1);

    // match while disabled
    wr(4'h1, 8'h00);
    wr(4'hC, 8'h05);
    do_tick();
    check("R8 no irq disabled", irq, 0);
    rd(4'h2, 8'h00, "R8 no status disabled");

    // re-enable with status pending
    wr(4'hC, 8'h06);
    wr(4'h1, 8'h80);
    do_tick();
    check("R10 irq second match", irq, 1);
    wr(4'h1, 8'h00);
    check("R10 no irq on disable", irq, 0);
    wr(4'h1, 8'h80);
    check("R10 irq on re-enable", irq, 1);
    rd(4'h2, 8'h01, "R10 status held");
    check("R10 pulse count", irq_cnt, 3);
    wr(4'h2, 8'h00);

    // disabled alarm with zero compare
    wr(4'h1, 8'h00);
    wr(4'hC, 8'h00);
    load_time(32'hFFFFFFFF);
    wr(4'h0, 8'h80);
    do_tick();
    check("R12 no irq through zero", irq, 0);
    rd_cnt(32'h0, "R12 count at zero");
    rd(4'h2, 8'h00, "R12 no status");
    check("R12 pulse count unchanged", irq_cnt, 3);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule